// File: doc/BRIEF.md
# Pipeline Operand Forwarding Selector

This block decides, for each of the two ALU operands of an in-order five-stage pipeline, where the operand value should come from. The execute stage holds two source register numbers. Two instructions that are further along the pipeline may still have to write their results back. One sits in the execute/memory pipeline register and the other in the memory/writeback pipeline register. The block compares each source number with both pending destinations. It produces a 2-bit select for each operand. The select picks the execute/memory result, the writeback result, or the value that was read from the register file. The producer that is closest to the execute stage wins, because it holds the newer value. Register zero is hardwired to zero, so it never takes part in forwarding.

A second function covers the register file read ports in the decode stage. When the register file is written in the same cycle that the same register is read, a per-port bypass flag tells the read path to return the incoming write data instead of the stored value. The ALU, the operand multiplexers and the pipeline registers are outside this block. All outputs are registered: they reflect the inputs sampled at the previous rising clock edge.

Top module: `operand_forward_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero on that edge.
- R2: An operand select becomes 2'b10 when `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals that operand's source number.
- R3: An operand select becomes 2'b01 when the R2 condition is false, `mwb_wr_en` is 1, `mwb_dst` is nonzero and `mwb_dst` equals that operand's source number.
- R4: When both the execute/memory and the memory/writeback stages match the same operand, the select is 2'b10.
- R5: A destination equal to register 0 never produces a forward, even with its write enable set.
- R6: A stage whose write enable is 0 never produces a forward, even when its destination matches.
- R7: When no valid match exists, the select is 2'b00, meaning the register-file value is used.
- R8: A read-port bypass flag is 1 exactly when `rf_wr_en` is 1, `rf_wr_addr` is nonzero and `rf_wr_addr` equals that port's read address; otherwise it is 0.
- R9: Each output shows the result for the inputs present at the preceding rising edge, and it does not change between edges.
- R10: Operand A (`ex_src_a`, `fwd_sel_a`) and operand B (`ex_src_b`, `fwd_sel_b`) are decided independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_src_a | input | REG_AW | First source register number in the execute stage |
| ex_src_b | input | REG_AW | Second source register number in the execute stage |
| exm_wr_en | input | 1 | Register-write flag held in the execute/memory register |
| exm_dst | input | REG_AW | Destination register number held in the execute/memory register |
| mwb_wr_en | input | 1 | Register-write flag held in the memory/writeback register |
| mwb_dst | input | REG_AW | Destination register number held in the memory/writeback register |
| rf_rd_addr_a | input | REG_AW | Register file read address, port A |
| rf_rd_addr_b | input | REG_AW | Register file read address, port B |
| rf_wr_en | input | 1 | Register file write enable |
| rf_wr_addr | input | REG_AW | Register file write address |
| fwd_sel_a | output | 2 | Operand A select: 00 register file, 01 writeback, 10 execute/memory |
| fwd_sel_b | output | 2 | Operand B select, same encoding |
| rf_byp_a | output | 1 | Read port A returns the write data |
| rf_byp_b | output | 1 | Read port B returns the write data |

## Verification
The hardest case to reach is the one where both pending producers name the same nonzero register, both write enables are set, and that register is also a source, while the other operand matches something different or nothing at all. The bench narrows the register number to two bits. It then sweeps every combination of both sources, both destinations and both write enables. This covers the double-match, register-zero and disabled-write cases on both operands at once. It also sweeps the full read-port bypass space and checks reset while matches are present.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
// One producer/consumer comparison: a write that is enabled, not to
// register zero, and to the same register number.
module fwd_match #(
  parameter int AW = 5
) (
  input  logic          wr_en,
  input  logic [AW-1:0] dst,
  input  logic [AW-1:0] src,
  output logic          hit
);
  always_comb begin
    hit = wr_en && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/fwd_operand_sel.sv
// Priority select for one ALU operand: the nearer stage wins.
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          [AW-1:0] src,
  input  logic                   exm_wr_en,
  input  logic          [AW-1:0] exm_dst,
  input  logic                   mwb_wr_en,
  input  logic          [AW-1:0] mwb_dst,
  output fwd_sel_e               sel
);
  logic exm_hit;
  logic mwb_hit;

  fwd_match #(.AW(AW)) u_exm (
    .wr_en(exm_wr_en), .dst(exm_dst), .src(src), .hit(exm_hit)
  );
  fwd_match #(.AW(AW)) u_mwb (
    .wr_en(mwb_wr_en), .dst(mwb_dst), .src(src), .hit(mwb_hit)
  );

  always_comb begin
    if (exm_hit)      sel = FWD_EXM;
    else if (mwb_hit) sel = FWD_MWB;
    else              sel = FWD_RF;
  end
endmodule

// File: rtl/rf_bypass_sel.sv
// Same-cycle write/read bypass flag for one register file read port.
module rf_bypass_sel #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          byp
);
  fwd_match #(.AW(AW)) u_cmp (
    .wr_en(wr_en), .dst(wr_addr), .src(rd_addr), .hit(byp)
  );
endmodule

// File: rtl/operand_forward_unit.sv
module operand_forward_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic              exm_wr_en,
  input  logic [REG_AW-1:0] exm_dst,
  input  logic              mwb_wr_en,
  input  logic [REG_AW-1:0] mwb_dst,
  input  logic [REG_AW-1:0] rf_rd_addr_a,
  input  logic [REG_AW-1:0] rf_rd_addr_b,
  input  logic              rf_wr_en,
  input  logic [REG_AW-1:0] rf_wr_addr,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic              rf_byp_a,
  output logic              rf_byp_b
);
  localparam int NUM_OPND = 2;
  localparam int NUM_RDP  = 2;

  logic [REG_AW-1:0] src_v  [NUM_OPND];
  logic [REG_AW-1:0] rda_v  [NUM_RDP];
  fwd_sel_e          sel_d  [NUM_OPND];
  logic [1:0]        sel_q  [NUM_OPND];
  logic              byp_d  [NUM_RDP];
  logic              byp_q  [NUM_RDP];
  logic              valid_q;

  assign src_v[0] = ex_src_a;
  assign src_v[1] = ex_src_b;
  assign rda_v[0] = rf_rd_addr_a;
  assign rda_v[1] = rf_rd_addr_b;

  always_ff @(posedge clk) begin
    valid_q <= !rst;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    fwd_operand_sel #(.AW(REG_AW)) u_sel (
      .src(src_v[g]),
      .exm_wr_en(exm_wr_en), .exm_dst(exm_dst),
      .mwb_wr_en(mwb_wr_en), .mwb_dst(mwb_dst),
      .sel(sel_d[g])
    );

    always_ff @(posedge clk) begin
      if (rst) sel_q[g] <= 2'b00;
      else     sel_q[g] <= sel_d[g];
    end

    // R2 / R4: a valid execute/memory match always yields 10
    a_r2_exm_wins: assert property (@(posedge clk) disable iff (rst)
      valid_q && $past(exm_wr_en && (exm_dst != '0) && (exm_dst == src_v[g]))
      |-> sel_q[g] == 2'b10);
    // R3: writeback match without an execute/memory match yields 01
    a_r3_mwb_only: assert property (@(posedge clk) disable iff (rst)
      valid_q && $past(!(exm_wr_en && exm_dst == src_v[g]) && mwb_wr_en
                       && (mwb_dst != '0) && (mwb_dst == src_v[g]))
      |-> sel_q[g] == 2'b01);
    // R5: register zero is never forwarded
    a_r5_zero_never: assert property (@(posedge clk) disable iff (rst)
      sel_q[g] != 2'b00 |-> $past(src_v[g]) != '0);
    // R6: a forward from a stage needs that stage's write enable
    a_r6_exm_needs_wr: assert property (@(posedge clk) disable iff (rst)
      sel_q[g] == 2'b10 |-> $past(exm_wr_en));
    a_r6_mwb_needs_wr: assert property (@(posedge clk) disable iff (rst)
      sel_q[g] == 2'b01 |-> $past(mwb_wr_en));
    // R7: the unused code 11 never appears
    a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
      sel_q[g] != 2'b11);
  end

  for (genvar p = 0; p < NUM_RDP; p++) begin : g_rdp
    rf_bypass_sel #(.AW(REG_AW)) u_byp (
      .rd_addr(rda_v[p]), .wr_en(rf_wr_en), .wr_addr(rf_wr_addr),
      .byp(byp_d[p])
    );

    always_ff @(posedge clk) begin
      if (rst) byp_q[p] <= 1'b0;
      else     byp_q[p] <= byp_d[p];
    end

    // R8: bypass flag follows the same-cycle write/read match
    a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
      valid_q |-> byp_q[p] == $past(rf_wr_en && (rf_wr_addr != '0)
                                   && (rf_wr_addr == rda_v[p])));
  end

  assign fwd_sel_a = sel_q[0];
  assign fwd_sel_b = sel_q[1];
  assign rf_byp_a  = byp_q[0];
  assign rf_byp_b  = byp_q[1];
endmodule

// File: tb/operand_forward_unit_bench.sv
`timescale 1ns/1ps
module operand_forward_unit_bench;
  localparam int AW = 2;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] ex_src_a = '0, ex_src_b = '0, exm_dst = '0, mwb_dst = '0;
  logic [AW-1:0] rf_rd_addr_a = '0, rf_rd_addr_b = '0, rf_wr_addr = '0;
  logic exm_wr_en = 1'b0, mwb_wr_en = 1'b0, rf_wr_en = 1'b0;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic rf_byp_a, rf_byp_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  operand_forward_unit #(.REG_AW(AW)) u_operand_forward_unit (
    .clk(clk), .rst(rst),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .exm_wr_en(exm_wr_en), .exm_dst(exm_dst),
    .mwb_wr_en(mwb_wr_en), .mwb_dst(mwb_dst),
    .rf_rd_addr_a(rf_rd_addr_a), .rf_rd_addr_b(rf_rd_addr_b),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .rf_byp_a(rf_byp_a), .rf_byp_b(rf_byp_b)
  );

  function automatic logic [1:0] exp_sel(int src, int me, int md, int we, int wd);
    if (me != 0 && md != 0 && md == src) return 2'b10;
    if (we != 0 && wd != 0 && wd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(int src, int me, int md, int we, int wd);
    bit mh = (me != 0 && md != 0 && md == src);
    bit wh = (we != 0 && wd != 0 && wd == src);
    if (mh && wh) return "R4";
    if (mh) return "R2";
    if (wh) return "R3";
    if (src == 0 && ((me != 0 && md == 0) || (we != 0 && wd == 0))) return "R5";
    if ((me == 0 && md == src) || (we == 0 && wd == src)) return "R6";
    return "R7";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset with matching inputs present
    ex_src_a = 1; ex_src_b = 2; exm_wr_en = 1; exm_dst = 1;
    mwb_wr_en = 1; mwb_dst = 2; rf_wr_en = 1; rf_wr_addr = 3;
    rf_rd_addr_a = 3; rf_rd_addr_b = 3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sel_a", fwd_sel_a, 0);
    chk("R1 sel_b", fwd_sel_b, 0);
    chk("R1 byp_a", rf_byp_a, 0);
    chk("R1 byp_b", rf_byp_b, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 after reset sel_a", fwd_sel_a, 2);
    chk("R3 after reset sel_b", fwd_sel_b, 1);
    chk("R8 after reset byp_a", rf_byp_a, 1);

    // R9: outputs keep old values until the next edge
    exm_wr_en = 0; mwb_wr_en = 0; rf_wr_en = 0;
    #5;
    chk("R9 hold sel_a", fwd_sel_a, 2);
    chk("R9 hold byp_b", rf_byp_b, 1);
    @(negedge clk);
    chk("R9 update sel_a", fwd_sel_a, 0);
    chk("R9 update byp_b", rf_byp_b, 0);

    // Exhaustive forwarding sweep (R2..R7, R10 on operand B)
    for (int i = 0; i < NR*NR*2*NR*2*NR; i++) begin
      int sa, sb, me, md, we, wd, t;
      t = i;
      sa = t % NR; t = t / NR;
      sb = t % NR; t = t / NR;
      me = t % 2;  t = t / 2;
      md = t % NR; t = t / NR;
      we = t % 2;  t = t / 2;
      wd = t % NR;
      ex_src_a = sa[AW-1:0]; ex_src_b = sb[AW-1:0];
      exm_wr_en = me[0]; exm_dst = md[AW-1:0];
      mwb_wr_en = we[0]; mwb_dst = wd[AW-1:0];
      @(negedge clk);
      chk({sel_tag(sa, me, md, we, wd), " sel_a"}, fwd_sel_a,
          exp_sel(sa, me, md, we, wd));
      chk({"R10 ", sel_tag(sb, me, md, we, wd), " sel_b"}, fwd_sel_b,
          exp_sel(sb, me, md, we, wd));
    end

    // Exhaustive read-port bypass sweep (R8)
    for (int i = 0; i < NR*NR*2*NR; i++) begin
      int ra, rb, en, wa, t;
      t = i;
      ra = t % NR; t = t / NR;
      rb = t % NR; t = t / NR;
      en = t % 2;  t = t / 2;
      wa = t % NR;
      rf_rd_addr_a = ra[AW-1:0]; rf_rd_addr_b = rb[AW-1:0];
      rf_wr_en = en[0]; rf_wr_addr = wa[AW-1:0];
      @(negedge clk);
      chk("R8 byp_a", rf_byp_a, (en != 0 && wa != 0 && wa == ra) ? 1 : 0);
      chk("R8 byp_b", rf_byp_b, (en != 0 && wa != 0 && wa == rb) ? 1 : 0);
    end

    // R1 again: reset mid-run clears active forwards
    ex_src_a = 3; exm_wr_en = 1; exm_dst = 3;
    @(negedge clk);
    chk("R2 pre-reset sel_a", fwd_sel_a, 2);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset sel_a", fwd_sel_a, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule